// File: doc/BRIEF.md
# Fixed-Latency Multiply-Accumulate Engine

This block holds a 48-bit two's-complement accumulator next to a single 24x24 signed multiplier, and a short command code selects what it does. Commands can clear the accumulator, load it from a 32-bit or 48-bit operand, store it to 32 or 48 bits, run one 32x32 multiply-accumulate, or compute a three-term 16-bit dot product. Operands come in on two parallel 48-bit ports. Every command runs for a fixed number of cycles, so software or a surrounding pipeline can schedule around the engine without polling.

The multiplier is time-shared. A 32x32 multiply-accumulate is split into four 16-bit partial products. The dot product uses one pass per term. Each pass takes one cycle to multiply and one cycle to add. A store places its value on a result port that keeps it until the next store finishes. A one-cycle done pulse marks the last cycle of every command.

Top module: `mac_acc_unit`

## Requirements
- R1: After reset, busy_o and done_o are low and result_o is zero. The accumulator is zero, so a 48-bit store issued first returns 0.
- R2: A command is accepted on a clock edge where cmd_valid_i is high, busy_o is low and cmd_op_i is a legal code. busy_o is then high for exactly the command's cycle count: clear 4, load32 9, load48 9, store32 7, store48 11, mac 8, dot 6. done_o is high only in the last of those cycles.
- R3: cmd_valid_i has no effect while busy_o is high. Code 7 is illegal, is never accepted, and changes neither busy_o nor the accumulator.
- R4: Clear (code 0) sets the accumulator to zero.
- R5: Load32 (code 1) writes opa_i[31:0], sign-extended to 48 bits, into the accumulator.
- R6: Load48 (code 2) writes opa_i[47:0] into the accumulator.
- R7: Store32 (code 3) sets result_o to the low 32 bits of the accumulator, with bits 47:32 zero.
- R8: Store48 (code 4) sets result_o to the full accumulator. result_o changes only on the edge that ends the done cycle of a store, and holds its value otherwise.
- R9: Mac (code 5) adds the signed product opa_i[31:0] * opb_i[31:0] to the accumulator.
- R10: Dot (code 6) replaces the accumulator with the sum of three signed 16x16 products. Each product uses the same 16-bit field of both operands, and the fields are bits 15:0, 31:16 and 47:32.
- R11: Every accumulator update wraps modulo 2^48 and never saturates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_op_i | input | 3 | Command code |
| opa_i | input | 48 | Operand A (load value, multiplicand, dot fields) |
| opb_i | input | 48 | Operand B (multiplier, dot fields) |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Last cycle of a command |
| result_o | output | 48 | Stored accumulator value |

## Verification
The assertions take for granted that cmd_op_i is sampled only on cycles where cmd_valid_i is high, and that an illegal code is dropped rather than queued. The latency check therefore follows the code captured on each accepted request. The stimulus mostly issues one legal command at a time, waiting for busy_o to fall before the next request. Only two directed cases break that pattern on purpose: one raises a request in the middle of a command, and one drives the illegal code. Operands are drawn across the full 48-bit range, so products with mixed signs and wrapping sums occur naturally.

// File: rtl/mac_pkg.sv
package mac_pkg;
  parameter int unsigned ACC_W  = 48;
  parameter int unsigned MUL_W  = 24;
  parameter int unsigned HALF_W = 16;
  parameter int unsigned DOT_N  = 3;
  parameter int unsigned CNT_W  = 4;
  localparam int unsigned WORD_W = 2 * HALF_W;

  typedef enum logic [2:0] {
    OP_CLR  = 3'd0,
    OP_LD32 = 3'd1,
    OP_LD48 = 3'd2,
    OP_ST32 = 3'd3,
    OP_ST48 = 3'd4,
    OP_MAC  = 3'd5,
    OP_DOT  = 3'd6
  } mac_op_e;

  function automatic logic [CNT_W-1:0] op_latency(logic [2:0] op);
    case (op)
      OP_CLR:  return CNT_W'(4);
      OP_LD32: return CNT_W'(9);
      OP_LD48: return CNT_W'(9);
      OP_ST32: return CNT_W'(7);
      OP_ST48: return CNT_W'(11);
      OP_MAC:  return CNT_W'(8);
      OP_DOT:  return CNT_W'(6);
      default: return CNT_W'(0);
    endcase
  endfunction

  function automatic logic op_legal(logic [2:0] op);
    return op <= OP_DOT;
  endfunction
endpackage

// File: rtl/mac_mul.sv
module mac_mul #(
  parameter int unsigned W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [W-1:0]     x_i,
  input  logic [W-1:0]     y_i,
  output logic [2*W-1:0]   p_o
);
  logic signed [2*W-1:0] full;
  assign full = $signed(x_i) * $signed(y_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   p_o <= '0;
    else if (en_i) p_o <= full;
  end
endmodule

// File: rtl/mac_opsel.sv
module mac_opsel
  import mac_pkg::*;
(
  input  logic [2:0]        op_i,
  input  logic [1:0]        step_i,
  input  logic [ACC_W-1:0]  a_i,
  input  logic [ACC_W-1:0]  b_i,
  output logic [MUL_W-1:0]  x_o,
  output logic [MUL_W-1:0]  y_o,
  output logic [1:0]        sh_o   // shift in HALF_W units
);
  localparam int unsigned PADW = MUL_W - HALF_W;

  logic [MUL_W-1:0] a_lo, a_hi, b_lo, b_hi;
  logic [MUL_W-1:0] ta [DOT_N];
  logic [MUL_W-1:0] tb [DOT_N];

  // low halves are unsigned, high halves carry the sign
  assign a_lo = {{PADW{1'b0}}, a_i[HALF_W-1:0]};
  assign b_lo = {{PADW{1'b0}}, b_i[HALF_W-1:0]};
  assign a_hi = {{PADW{a_i[WORD_W-1]}}, a_i[WORD_W-1:HALF_W]};
  assign b_hi = {{PADW{b_i[WORD_W-1]}}, b_i[WORD_W-1:HALF_W]};

  for (genvar k = 0; k < DOT_N; k++) begin : g_term
    assign ta[k] = {{PADW{a_i[HALF_W*k+HALF_W-1]}}, a_i[HALF_W*k +: HALF_W]};
    assign tb[k] = {{PADW{b_i[HALF_W*k+HALF_W-1]}}, b_i[HALF_W*k +: HALF_W]};
  end

  always_comb begin
    x_o  = '0;
    y_o  = '0;
    sh_o = 2'd0;
    if (op_i == OP_DOT) begin
      for (int k = 0; k < DOT_N; k++) begin
        if (step_i == 2'(k)) begin
          x_o = ta[k];
          y_o = tb[k];
        end
      end
    end else begin
      case (step_i)
        2'd0: begin x_o = a_lo; y_o = b_lo; sh_o = 2'd0; end
        2'd1: begin x_o = a_lo; y_o = b_hi; sh_o = 2'd1; end
        2'd2: begin x_o = a_hi; y_o = b_lo; sh_o = 2'd1; end
        default: begin x_o = a_hi; y_o = b_hi; sh_o = 2'd2; end
      endcase
    end
  end
endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cmd_valid_i,
  input  logic [2:0]  cmd_op_i,
  output logic        accept_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [2:0]  op_o,
  output logic        mul_en_o,
  output logic        add_en_o,
  output logic [1:0]  step_o
);
  logic             busy_q;
  logic [2:0]       op_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       step_q;
  logic             arith;

  assign accept_o = cmd_valid_i && !busy_q && op_legal(cmd_op_i);
  assign busy_o   = busy_q;
  assign done_o   = busy_q && (cnt_q == '0);
  assign op_o     = op_q;
  assign step_o   = step_q;
  assign arith    = (op_q == OP_MAC) || (op_q == OP_DOT);
  // odd count: multiply pass, even count: accumulate pass
  assign mul_en_o = busy_q && arith && cnt_q[0];
  assign add_en_o = busy_q && arith && !cnt_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= '0;
      cnt_q  <= '0;
      step_q <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      op_q   <= cmd_op_i;
      cnt_q  <= op_latency(cmd_op_i) - CNT_W'(1);
      step_q <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
      if (add_en_o)    step_q <= step_q + 2'd1;
    end
  end
endmodule

// File: rtl/mac_acc_unit.sv
module mac_acc_unit
  import mac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ACC_W-1:0]  opa_i,
  input  logic [ACC_W-1:0]  opb_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ACC_W-1:0]  result_o
);
  localparam int unsigned PROD_W = 2 * MUL_W;

  logic              accept, mul_en, add_en;
  logic [2:0]        op_q;
  logic [1:0]        step, sh;
  logic [ACC_W-1:0]  a_q, b_q, acc_q, res_q, prod_ext;
  logic [MUL_W-1:0]  mx, my;
  logic [PROD_W-1:0] prod_q;

  mac_ctrl u_ctrl (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i,
    .accept_o(accept), .busy_o, .done_o, .op_o(op_q),
    .mul_en_o(mul_en), .add_en_o(add_en), .step_o(step)
  );

  mac_opsel u_opsel (
    .op_i(op_q), .step_i(step), .a_i(a_q), .b_i(b_q),
    .x_o(mx), .y_o(my), .sh_o(sh)
  );

  mac_mul #(.W(MUL_W)) u_mul (
    .clk_i, .rst_ni, .en_i(mul_en), .x_i(mx), .y_i(my), .p_o(prod_q)
  );

  assign prod_ext = ACC_W'($signed(prod_q));
  assign result_o = res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      acc_q <= '0;
      res_q <= '0;
    end else begin
      if (accept) begin
        a_q <= opa_i;
        b_q <= opb_i;
        if (cmd_op_i == OP_DOT) acc_q <= '0;
      end
      if (add_en) begin
        acc_q <= acc_q + (prod_ext << (HALF_W * sh));  // wraps mod 2^ACC_W
      end else if (done_o) begin
        case (op_q)
          OP_CLR:  acc_q <= '0;
          OP_LD32: acc_q <= ACC_W'($signed(a_q[WORD_W-1:0]));
          OP_LD48: acc_q <= a_q;
          OP_ST32: res_q <= {{(ACC_W-WORD_W){1'b0}}, acc_q[WORD_W-1:0]};
          OP_ST48: res_q <= acc_q;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mac_acc_unit_chk.sv
module mac_acc_unit_chk
  import mac_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [2:0]        cmd_op_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [ACC_W-1:0]  result_o
);
  logic             take;
  logic [2:0]       op_seen;
  logic [CNT_W-1:0] run_cnt;

  assign take = cmd_valid_i && !busy_o && (cmd_op_i != 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_seen <= '0;
      run_cnt <= '0;
    end else if (take) begin
      op_seen <= cmd_op_i;
      run_cnt <= '0;
    end else if (busy_o) begin
      run_cnt <= run_cnt + CNT_W'(1);
    end
  end

  a_r2_accept_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> busy_o);
  a_r2_done_inside_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  a_r2_fixed_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (run_cnt == op_latency(op_seen) - CNT_W'(1)));
  a_r2_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  a_r3_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  a_r3_illegal_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !busy_o && cmd_op_i == 3'd7) |=> !busy_o);
  a_r8_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |=> $stable(result_o));
endmodule

bind mac_acc_unit mac_acc_unit_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
  .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
);

// File: tb/mac_acc_unit_bench.sv
module mac_acc_unit_bench;
  localparam int C_CLR = 0, C_LD32 = 1, C_LD48 = 2, C_ST32 = 3,
                 C_ST48 = 4, C_MAC = 5, C_DOT = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [2:0]  cmd_op_i = '0;
  logic [47:0] opa_i = '0, opb_i = '0;
  logic        busy_o, done_o;
  logic [47:0] result_o;

  int n_chk = 0, n_fail = 0;
  logic [47:0] m_acc = '0;
  logic [47:0] m_res = '0;

  always #10 clk_i = ~clk_i;

  mac_acc_unit u_mac_acc_unit (.*);

  function automatic int lat(int op);
    case (op)
      C_CLR: return 4;  C_LD32: return 9; C_LD48: return 9;
      C_ST32: return 7; C_ST48: return 11; C_MAC: return 8;
      default: return 6;
    endcase
  endfunction

  function automatic logic [47:0] f_mac(logic [47:0] acc, logic [47:0] a, logic [47:0] b);
    longint x, y, p;
    x = $signed(a[31:0]);
    y = $signed(b[31:0]);
    p = x * y;
    return acc + p[47:0];
  endfunction

  function automatic logic [47:0] f_dot(logic [47:0] a, logic [47:0] b);
    longint s = 0;
    for (int k = 0; k < 3; k++) begin
      longint x, y;
      x = $signed(a[16*k +: 16]);
      y = $signed(b[16*k +: 16]);
      s += x * y;
    end
    return s[47:0];
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // issue one command; inject=1 raises a load48 request mid-command (R3)
  task automatic run_cmd(int op, logic [47:0] a, logic [47:0] b, bit inject = 0);
    int n;
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = 3'(op); opa_i = a; opb_i = b;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    n = 1;
    while (!done_o && n < 20) begin
      if (inject && n == 2) begin
        cmd_valid_i = 1'b1; cmd_op_i = 3'(C_LD48); opa_i = '1;
      end else begin
        cmd_valid_i = 1'b0;
      end
      @(negedge clk_i);
      n++;
    end
    cmd_valid_i = 1'b0;
    chk(n == lat(op), "R2 latency", 64'(n), 64'(lat(op)));
    case (op)
      C_CLR:  m_acc = '0;
      C_LD32: m_acc = 48'($signed(a[31:0]));
      C_LD48: m_acc = a;
      C_ST32: m_res = {16'h0, m_acc[31:0]};
      C_ST48: m_res = m_acc;
      C_MAC:  m_acc = f_mac(m_acc, a, b);
      default: m_acc = f_dot(a, b);
    endcase
    @(negedge clk_i);
    chk(!busy_o, "R2 idle after done", 64'(busy_o), 64'(0));
    if (op == C_ST32) chk(result_o == m_res, "R7 store32", 64'(result_o), 64'(m_res));
    if (op == C_ST48) chk(result_o == m_res, "R8 store48", 64'(result_o), 64'(m_res));
  endtask

  task automatic peek(string req);
    run_cmd(C_ST48, '0, '0);
    chk(result_o == m_acc, req, 64'(result_o), 64'(m_acc));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog actual=hang expected=finish");
    finish_run();
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o, "R1 reset idle", 64'({busy_o, done_o}), 64'(0));
    chk(result_o == '0, "R1 reset result", 64'(result_o), 64'(0));
    peek("R1 acc zero");

    run_cmd(C_LD32, 48'h1234_8000_0001, '0);
    peek("R5 load32 sign extend");
    run_cmd(C_ST32, '0, '0);
    run_cmd(C_LD48, 48'h8765_4321_0FED, '0);
    peek("R6 load48");
    run_cmd(C_CLR, '0, '0);
    peek("R4 clear");

    // R11 wrap at top of range
    run_cmd(C_LD48, 48'h7FFF_FFFF_FFFF, '0);
    run_cmd(C_MAC, 48'h1, 48'h1);
    chk(m_acc == 48'h8000_0000_0000, "R11 model wrap", 64'(m_acc), 64'h8000_0000_0000);
    peek("R11 mac wrap");
    run_cmd(C_MAC, 48'hFFFF_FFFF, 48'h8000_0000);
    peek("R9 mac mixed sign");
    run_cmd(C_MAC, 48'h8000_0000, 48'h8000_0000);
    peek("R9 mac max negative");

    run_cmd(C_DOT, 48'h8000_8000_8000, 48'h8000_8000_8000);
    peek("R10 dot max negative");
    run_cmd(C_DOT, 48'h0003_FFFF_7FFF, 48'h0005_0002_7FFF);
    peek("R10 dot mixed");

    // R8 hold: result_o kept across non-store commands
    run_cmd(C_ST48, '0, '0);
    run_cmd(C_LD48, 48'h0A0A_0A0A_0A0A, '0);
    chk(result_o == m_res, "R8 result held", 64'(result_o), 64'(m_res));

    // R3 request while busy
    run_cmd(C_MAC, 48'h3, 48'h5, 1'b1);
    peek("R3 busy request ignored");
    // R3 illegal code
    @(negedge clk_i);
    cmd_valid_i = 1'b1; cmd_op_i = 3'd7; opa_i = '1;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
    chk(!busy_o, "R3 illegal code not accepted", 64'(busy_o), 64'(0));
    peek("R3 illegal code no effect");

    for (int i = 0; i < 400; i++) begin
      int op;
      logic [47:0] a, b;
      op = int'($urandom_range(0, 6));
      a = {16'($urandom), $urandom};
      b = {16'($urandom), $urandom};
      run_cmd(op, a, b);
      if (op == C_MAC || op == C_DOT) peek(op == C_MAC ? "R9 random mac" : "R10 random dot");
    end
    finish_run();
  end
endmodule